// File: doc/BRIEF.md
# Streaming Pixel Format Packer

The packer accepts one pixel per clock as four 8-bit channels (red, green, blue, alpha) over a valid/ready handshake. It converts each pixel to a memory representation that a 4-bit format code selects, and emits 32-bit words, each with a 4-bit byte-write mask, over a second valid/ready handshake. The same code sets both the bit depth (16, 24 or 32 bits per pixel) and the order of the channels inside the pixel.

Alpha handling is set by two configuration bits. Alpha can be stored as is, stored inverted, or replaced by a constant fill byte of all ones or all zeros. A 4-bit lane-enable input gates the write mask of every output word. Three-byte pixels run across word boundaries. An end-of-line flag on the last pixel of a line pushes out any partly filled word. The configuration inputs must stay constant while a line is streaming.

Top module: `pix_fmt_packer`

## Requirements
- R1: Format codes 0-3 give 16-bit 4444 pixels, 6-7 give 16-bit 565 pixels, 8-9 give 24-bit pixels and 12-15 give 32-bit pixels. A word is emitted only when four bytes have gathered, or when a line ends.
- R2: A 32-bit pixel lists its channels from out_word[31:24] down to [7:0]. Code 12 gives A,B,G,R. Code 13 gives A,R,G,B. Code 14 gives B,G,R,A. Code 15 gives R,G,B,A.
- R3: A 4444 pixel keeps the top four bits of each channel, in nibbles from bit 15 down to bit 0. Code 0 gives A,B,G,R. Code 1 gives A,R,G,B. Code 2 gives B,G,R,A. Code 3 gives R,G,B,A.
- R4: A 565 pixel is built from red[7:3], green[7:2] and blue[7:3]. Code 7 puts red in bits 15:11 and blue in bits 4:0. Code 6 swaps red and blue.
- R5: Two 16-bit pixels fill one word. The first pixel accepted goes in bits 15:0 and the second in bits 31:16.
- R6: A 24-bit pixel is a value with red above green above blue (code 9), or blue above green above red (code 8). Its bytes are stored low byte first, with no gaps, so four pixels fill exactly three words, and the earliest byte goes in lane 0.
- R7: With alpha_keep=1, the alpha byte is stored unchanged when alpha_inv=0 and stored bitwise inverted when alpha_inv=1.
- R8: With alpha_keep=0, the alpha field is filled with all ones when alpha_inv=1 and with all zeros when alpha_inv=0.
- R9: out_be bit i is set only when byte lane i (out_word[8i+7:8i]) holds pixel data and lane_en[i] is 1. lane_en has no effect on out_word.
- R10: A pixel with in_eol=1 flushes the bytes still held. They go out as one last word with only its low valid lanes enabled and zeros elsewhere, and a full word that is due goes out first.
- R11: Codes 4, 5, 10 and 11 consume the pixel and produce no output word.
- R12: While out_valid=1 and out_ready=0, out_word and out_be hold and in_ready is 0. No pixel is lost or repeated under backpressure.
- R13: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_code | input | 4 | Format and channel-order code |
| alpha_keep | input | 1 | 1: store alpha; 0: fill alpha field |
| alpha_inv | input | 1 | Invert stored alpha, or choose all-ones fill |
| lane_en | input | 4 | Per-lane gate on the byte-write mask |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Packer can accept a pixel |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_a | input | 8 | Alpha channel |
| in_eol | input | 1 | Pixel is the last of its line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed memory word |
| out_be | output | 4 | Byte-write mask for out_word |

## Verification
A word that a pixel completes appears on out_valid in the cycle after the rising edge that accepts that pixel. When a line ends with one full word and some leftover bytes, the partial flush word appears one cycle after the full word has been taken. The bench changes inputs just after a rising edge and samples all outputs and handshakes at the falling edge. It logs every word transferred in order, waits a fixed drain interval, and then compares the logged words and masks to values worked out by hand from the requirements. In the stall scenario, out_word, out_be and in_ready are checked on several consecutive falling edges while out_ready is held low.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int CH_W    = 8;
  localparam int WORD_B  = 4;
  localparam int WORD_W  = WORD_B * 8;
  localparam int RES_B   = WORD_B - 1;
  localparam int RES_W   = RES_B * 8;
  localparam int CAT_W   = WORD_W + RES_W;
  localparam int CNT_W   = $clog2(WORD_B + RES_B + 1);
  localparam int RCNT_W  = $clog2(WORD_B);

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_16   = 2'd1,
    CLS_24   = 2'd2,
    CLS_32   = 2'd3
  } pix_cls_e;

  function automatic pix_cls_e classify(input logic [3:0] code);
    pix_cls_e c;
    case (code[3:2])
      2'b00:   c = CLS_16;
      2'b01:   c = code[1] ? CLS_16 : CLS_NONE;
      2'b10:   c = code[1] ? CLS_NONE : CLS_24;
      default: c = CLS_32;
    endcase
    return c;
  endfunction

  function automatic logic [WORD_B-1:0] low_mask(input logic [CNT_W-1:0] n);
    logic [WORD_B-1:0] m;
    for (int i = 0; i < WORD_B; i++) m[i] = (n > CNT_W'(i));
    return m;
  endfunction
endpackage

// File: rtl/pfp_encoder.sv
module pfp_encoder
  import pfp_pkg::*;
(
  input  logic [3:0]        code,
  input  logic              alpha_keep,
  input  logic              alpha_inv,
  input  logic [CH_W-1:0]   r,
  input  logic [CH_W-1:0]   g,
  input  logic [CH_W-1:0]   b,
  input  logic [CH_W-1:0]   a,
  output logic [WORD_W-1:0] pix,
  output logic [CNT_W-1:0]  nbytes
);
  logic [CH_W-1:0] a_eff, c_hi, c_mid, c_lo;
  logic            alpha_top;
  pix_cls_e        cls;

  always_comb begin
    if (alpha_keep) a_eff = alpha_inv ? ~a : a;
    else            a_eff = alpha_inv ? {CH_W{1'b1}} : {CH_W{1'b0}};
    c_hi      = code[0] ? r : b;
    c_mid     = g;
    c_lo      = code[0] ? b : r;
    alpha_top = ~code[1];
    cls       = classify(code);
    pix       = '0;
    nbytes    = '0;
    case (cls)
      CLS_16: begin
        nbytes = CNT_W'(2);
        if (code[3:2] == 2'b00)
          pix[15:0] = alpha_top ? {a_eff[7:4], c_hi[7:4], c_mid[7:4], c_lo[7:4]}
                                : {c_hi[7:4], c_mid[7:4], c_lo[7:4], a_eff[7:4]};
        else
          pix[15:0] = {c_hi[7:3], c_mid[7:2], c_lo[7:3]};
      end
      CLS_24: begin
        nbytes     = CNT_W'(3);
        pix[23:0]  = {c_hi, c_mid, c_lo};
      end
      CLS_32: begin
        nbytes = CNT_W'(4);
        pix    = alpha_top ? {a_eff, c_hi, c_mid, c_lo} : {c_hi, c_mid, c_lo, a_eff};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pfp_packer.sv
module pfp_packer
  import pfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_eol,
  input  logic [WORD_W-1:0] pix,
  input  logic [CNT_W-1:0]  nbytes,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [WORD_B-1:0] out_mask
);
  logic [RES_W-1:0]  res_q, res_n;
  logic [RCNT_W-1:0] rcnt_q, rcnt_n;
  logic              flush_q, flush_n;
  logic              ovld_q, ovld_n;
  logic [WORD_W-1:0] oword_q, oword_n;
  logic [WORD_B-1:0] omask_q, omask_n;
  logic              take, out_free, load_out, st_en;
  logic [CAT_W-1:0]  cat;
  logic [CNT_W-1:0]  tot, rem;

  assign out_free = !ovld_q || out_ready;
  assign in_ready = !flush_q && out_free;
  assign take     = in_valid && in_ready;

  always_comb begin
    cat      = {{WORD_W{1'b0}}, res_q} | ({{RES_W{1'b0}}, pix} << {rcnt_q, 3'b000});
    tot      = CNT_W'(rcnt_q) + nbytes;
    rem      = tot - CNT_W'(WORD_B);
    res_n    = res_q;
    rcnt_n   = rcnt_q;
    flush_n  = flush_q;
    oword_n  = oword_q;
    omask_n  = omask_q;
    load_out = 1'b0;
    if (take) begin
      if (tot >= CNT_W'(WORD_B)) begin
        load_out = 1'b1;
        oword_n  = cat[WORD_W-1:0];
        omask_n  = {WORD_B{1'b1}};
        res_n    = cat[CAT_W-1:WORD_W];
        rcnt_n   = rem[RCNT_W-1:0];
        flush_n  = in_eol && (rem != '0);
      end else if (in_eol && tot != '0) begin
        load_out = 1'b1;
        oword_n  = cat[WORD_W-1:0];
        omask_n  = low_mask(tot);
        res_n    = '0;
        rcnt_n   = '0;
      end else begin
        res_n    = cat[RES_W-1:0];
        rcnt_n   = tot[RCNT_W-1:0];
      end
    end else if (flush_q && out_free) begin
      load_out = 1'b1;
      oword_n  = {{(WORD_W-RES_W){1'b0}}, res_q};
      omask_n  = low_mask(CNT_W'(rcnt_q));
      res_n    = '0;
      rcnt_n   = '0;
      flush_n  = 1'b0;
    end
    ovld_n = load_out || (ovld_q && !out_ready);
    st_en  = take || load_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      rcnt_q  <= '0;
      flush_q <= 1'b0;
      ovld_q  <= 1'b0;
      oword_q <= '0;
      omask_q <= '0;
    end else begin
      ovld_q <= ovld_n;
      if (st_en) begin
        res_q   <= res_n;
        rcnt_q  <= rcnt_n;
        flush_q <= flush_n;
      end
      if (load_out) begin
        oword_q <= oword_n;
        omask_q <= omask_n;
      end
    end
  end

  assign out_valid = ovld_q;
  assign out_word  = oword_q;
  assign out_mask  = omask_q;

  // R12: a stalled word is held unchanged
  p_hold_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_mask)));

  // R10: emitted lanes are always a contiguous run from lane 0
  p_mask_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask == 4'h1 || out_mask == 4'h3 || out_mask == 4'h7 || out_mask == 4'hF));
endmodule

// File: rtl/pix_fmt_packer.sv
module pix_fmt_packer
  import pfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fmt_code,
  input  logic              alpha_keep,
  input  logic              alpha_inv,
  input  logic [WORD_B-1:0] lane_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_r,
  input  logic [CH_W-1:0]   in_g,
  input  logic [CH_W-1:0]   in_b,
  input  logic [CH_W-1:0]   in_a,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [WORD_B-1:0] out_be
);
  logic              rst_meta, rst_s;
  logic [WORD_W-1:0] enc_pix;
  logic [CNT_W-1:0]  enc_nb;
  logic [WORD_B-1:0] raw_mask;
  logic              reserved_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  pfp_encoder u_enc (
    .code       (fmt_code),
    .alpha_keep (alpha_keep),
    .alpha_inv  (alpha_inv),
    .r          (in_r),
    .g          (in_g),
    .b          (in_b),
    .a          (in_a),
    .pix        (enc_pix),
    .nbytes     (enc_nb)
  );

  pfp_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (in_valid),
    .in_eol    (in_eol),
    .pix       (enc_pix),
    .nbytes    (enc_nb),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_mask  (raw_mask)
  );

  assign out_be = raw_mask & lane_en;

  assign reserved_code = (fmt_code[3:1] == 3'b010) || (fmt_code[3:1] == 3'b101);

  // R11: a reserved-code pixel never creates a word
  p_reserved_silent_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready && reserved_code && !in_eol && !out_valid) |=> !out_valid);

  // R1: an accepted 32-bit pixel always completes a word
  p_full_word_32_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready && fmt_code[3:2] == 2'b11) |=> out_valid);
endmodule

// File: tb/tb_pix_fmt_packer.sv
module tb_pix_fmt_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  fmt_code;
  logic        alpha_keep, alpha_inv;
  logic [3:0]  lane_en;
  logic        in_valid, in_ready, in_eol;
  logic [7:0]  in_r, in_g, in_b, in_a;
  logic        out_valid, out_ready;
  logic [31:0] out_word;
  logic [3:0]  out_be;

  int total = 0;
  int bad   = 0;
  int nrec  = 0;
  int cyc   = 0;
  logic [31:0] wq [0:63];
  logic [3:0]  bq [0:63];

  always #5 clk = ~clk;

  pix_fmt_packer dut (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .alpha_keep(alpha_keep),
    .alpha_inv(alpha_inv), .lane_en(lane_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_a(in_a), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_be(out_be)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && nrec < 64) begin
      wq[nrec] = out_word;
      bq[nrec] = out_be;
      nrec++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                      input logic [7:0] a, input logic eol);
    @(posedge clk); #1;
    in_valid = 1'b1; in_r = r; in_g = g; in_b = b; in_a = a; in_eol = eol;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_eol = 1'b0;
  endtask

  task automatic drain();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [3:0] c, input logic k, input logic v);
    @(posedge clk); #1;
    fmt_code = c; alpha_keep = k; alpha_inv = v;
  endtask

  task automatic word_at(input int idx, input logic [31:0] w, input logic [3:0] be,
                         input string req);
    check({req, " word"}, wq[idx], w);
    check({req, " be"}, {28'b0, bq[idx]}, {28'b0, be});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R13 out_valid", {31'b0, out_valid}, 32'd0);
    check("R13 in_ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_orders_32();
    int base = nrec;
    cfg(4'd13, 1, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    cfg(4'd12, 1, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    cfg(4'd14, 1, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    cfg(4'd15, 1, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    drain();
    word_at(base + 0, 32'h44112233, 4'hF, "R2 code13");
    word_at(base + 1, 32'h44332211, 4'hF, "R2 code12");
    word_at(base + 2, 32'h33221144, 4'hF, "R2 code14");
    word_at(base + 3, 32'h11223344, 4'hF, "R2 code15");
  endtask

  task automatic t_alpha();
    int base = nrec;
    cfg(4'd13, 1, 1); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    cfg(4'd13, 0, 1); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    cfg(4'd13, 0, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    drain();
    word_at(base + 0, 32'hBB112233, 4'hF, "R7 invert");
    word_at(base + 1, 32'hFF112233, 4'hF, "R8 fill ones");
    word_at(base + 2, 32'h00112233, 4'hF, "R8 fill zeros");
  endtask

  task automatic t_16bit();
    int base = nrec;
    cfg(4'd1, 1, 0);
    send(8'hA5, 8'h5A, 8'hC3, 8'hF0, 0); send(8'h12, 8'h34, 8'h56, 8'h78, 0);
    cfg(4'd2, 1, 0);
    send(8'hA5, 8'h5A, 8'hC3, 8'hF0, 0); send(8'h12, 8'h34, 8'h56, 8'h78, 0);
    cfg(4'd7, 1, 0);
    send(8'hFF, 8'h00, 8'hFF, 8'h00, 0); send(8'h12, 8'h34, 8'h56, 8'h00, 0);
    cfg(4'd6, 1, 0);
    send(8'hFF, 8'h00, 8'hFF, 8'h00, 0); send(8'h12, 8'h34, 8'h56, 8'h00, 0);
    drain();
    check("R1 R5 two 16-bit pixels per word", nrec - base, 4);
    word_at(base + 0, 32'h7135FA5C, 4'hF, "R3 R5 code1");
    word_at(base + 1, 32'h5317C5AF, 4'hF, "R3 code2");
    word_at(base + 2, 32'h11AAF81F, 4'hF, "R4 code7");
    word_at(base + 3, 32'h51A2F81F, 4'hF, "R4 code6");
  endtask

  task automatic t_24bit();
    int base = nrec;
    cfg(4'd9, 1, 0);
    for (int k = 0; k < 4; k++)
      send(8'(16*k + 1), 8'(16*k + 2), 8'(16*k + 3), 8'h00, k == 3);
    drain();
    check("R1 R6 four pixels give three words", nrec - base, 3);
    word_at(base + 0, 32'h13010203, 4'hF, "R6 w0");
    word_at(base + 1, 32'h22231112, 4'hF, "R6 w1");
    word_at(base + 2, 32'h31323321, 4'hF, "R6 w2");
  endtask

  task automatic t_flush();
    int base = nrec;
    cfg(4'd8, 1, 0);
    send(8'hAA, 8'hBB, 8'hCC, 8'h00, 1);
    cfg(4'd9, 1, 0);
    for (int k = 0; k < 3; k++)
      send(8'(16*k + 1), 8'(16*k + 2), 8'(16*k + 3), 8'h00, k == 2);
    drain();
    check("R10 word count", nrec - base, 4);
    word_at(base + 0, 32'h00CCBBAA, 4'h7, "R10 R6 code8 partial");
    word_at(base + 1, 32'h13010203, 4'hF, "R10 full0");
    word_at(base + 2, 32'h22231112, 4'hF, "R10 full1");
    word_at(base + 3, 32'h00000021, 4'h1, "R10 flush one byte");
  endtask

  task automatic t_lanes();
    int base = nrec;
    cfg(4'd13, 1, 0);
    lane_en = 4'h5;
    send(8'h11, 8'h22, 8'h33, 8'h44, 0);
    drain();
    lane_en = 4'hF;
    word_at(base, 32'h44112233, 4'h5, "R9 lane gate");
  endtask

  task automatic t_reserved();
    int base = nrec;
    cfg(4'd4, 1, 0);  send(8'h11, 8'h22, 8'h33, 8'h44, 1);
    cfg(4'd5, 1, 0);  send(8'h11, 8'h22, 8'h33, 8'h44, 1);
    cfg(4'd10, 1, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 1);
    cfg(4'd11, 1, 0); send(8'h11, 8'h22, 8'h33, 8'h44, 1);
    drain();
    check("R11 no words from reserved codes", nrec - base, 0);
    cfg(4'd15, 1, 0); send(8'h55, 8'h66, 8'h77, 8'h88, 0);
    drain();
    check("R11 next valid pixel count", nrec - base, 1);
    word_at(base, 32'h55667788, 4'hF, "R11 after reserved");
  endtask

  task automatic t_stall();
    int base = nrec;
    cfg(4'd13, 1, 0);
    out_ready = 1'b0;
    send(8'h01, 8'h02, 8'h03, 8'h04, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 held valid", {31'b0, out_valid}, 32'd1);
      check("R12 held word", out_word, 32'h04010203);
      check("R12 in_ready low", {31'b0, in_ready}, 32'd0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    send(8'h0A, 8'h0B, 8'h0C, 8'h0D, 0);
    drain();
    check("R12 count", nrec - base, 2);
    word_at(base + 0, 32'h04010203, 4'hF, "R12 first");
    word_at(base + 1, 32'h0D0A0B0C, 4'hF, "R12 second");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_eol = 1'b0; out_ready = 1'b1;
    in_r = '0; in_g = '0; in_b = '0; in_a = '0;
    fmt_code = 4'd13; alpha_keep = 1'b1; alpha_inv = 1'b0; lane_en = 4'hF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_orders_32();
    t_alpha();
    t_16bit();
    t_24bit();
    t_flush();
    t_lanes();
    t_reserved();
    t_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule